// File: doc/BRIEF.md
# Multi-Cycle Processor Core with a Shared Memory Port

A 32-bit processor core that runs each instruction over a variable number of clock cycles. One combinational-read memory port serves both instruction fetch and data access. One ALU serves three purposes: it advances the program counter, forms the branch target, and computes results and addresses. Staging registers carry values between cycles: the instruction, the loaded data, two operands and the ALU result. Operand multiplexers in front of the ALU and a multiplexer on the memory address let the same hardware do different work in different cycles.

The core supports six operations: word load, word store, register add, register AND, branch-if-equal and jump. It has a 32-entry register file in which entry 0 always reads as zero. Programs start at address 0 after reset. The surrounding system attaches a word memory to the address, write-data, write-enable and read-data ports.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mem_addr` is 0 and `mem_we` is 0, so the first instruction is fetched from address 0.
- R2: Every instruction starts with a fetch cycle that presents the program counter on `mem_addr` and advances it by 4. Instruction lengths are fixed: load 5 cycles, store 4, register add or AND 4, branch 3, jump 2. An unrecognised opcode takes 2 cycles and has no effect.
- R3: Load uses opcode 0x23 in bits [31:26], base register in [25:21], destination register in [20:16] and a 16-bit offset in [15:0]. It writes the word at base+offset into the destination. The data address appears on `mem_addr` in the fourth cycle of the instruction.
- R4: Store uses opcode 0x2B with the same field layout as load. It writes the register in [20:16] to base+offset. `mem_we` is high for exactly one cycle per store, in the store's fourth cycle.
- R5: Register operations use opcode 0, sources in [25:21] and [20:16], destination in [15:11] and a function code in [5:0]. Function 0x20 writes the sum of the sources and 0x24 writes their bitwise AND.
- R6: Branch-if-equal uses opcode 0x04 with two compared registers in [25:21] and [20:16]. When they are equal, execution continues at the branch address + 4 + (sign-extended offset × 4). Otherwise it continues at the branch address + 4.
- R7: Jump uses opcode 0x02. Execution continues at the address formed from bits [31:28] of (jump address + 4), then instruction bits [25:0], then two zero bits.
- R8: Register 0 always reads as zero, and any write aimed at it is discarded.
- R9: The 16-bit offset of load, store and branch is sign-extended, so an offset of 0xFFFC addresses the word just below the base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Byte address: program counter in fetch cycles, data address in access cycles |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Memory write strobe, applied at the rising edge |
| mem_rdata | input | 32 | Word read combinationally from `mem_addr` |

## Verification
The assertions take three things for granted. Reset is held for at least one rising edge before the first instruction. `mem_rdata` settles within the cycle to the word at `mem_addr`. The program is made only of the six supported encodings. The bench meets these conditions with a fully preloaded word-array memory that reads combinationally, and a reset held for several cycles both at start-up and again in the middle of the run. The program keeps its code, its data and its halt loop at separate addresses, so the first appearance of the halt address on `mem_addr` marks the halt fetch exactly.

// File: rtl/mc_core.sv
module mc_core (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  input  logic [31:0] mem_rdata
);
  localparam logic [2:0] S_IF = 3'd0, S_ID = 3'd1, S_EX = 3'd2, S_MEM = 3'd3, S_WB = 3'd4;
  localparam logic [5:0] OP_R = 6'h00, OP_J = 6'h02, OP_BEQ = 6'h04, OP_LW = 6'h23, OP_SW = 6'h2B;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [1:0] ALU_ADD = 2'd0, ALU_AND = 2'd1, ALU_SUB = 2'd2;
  localparam logic [1:0] B_REG = 2'd0, B_FOUR = 2'd1, B_IMM = 2'd2, B_IMM4 = 2'd3;
  localparam logic [1:0] PC_ALU = 2'd0, PC_RES = 2'd1, PC_JMP = 2'd2;

  logic [2:0]  state, state_nx;
  logic [31:0] pc, ir, dr, a_q, b_q, res;
  logic [31:0] rf [32];

  logic [5:0]  opc, funct;
  logic [4:0]  rs, rt, rd, wr_addr;
  logic [31:0] simm, simm4, jtgt, alu_a, alu_b, alu_y, wr_data, pc_nx;
  logic        alu_zero;

  logic        ir_we, pc_we, ab_we, res_we, dr_we, rf_we, iord, asel, wb_dr, dst_rd;
  logic [1:0]  bsel, alu_op, pc_src;

  assign opc   = ir[31:26];
  assign rs    = ir[25:21];
  assign rt    = ir[20:16];
  assign rd    = ir[15:11];
  assign funct = ir[5:0];
  assign simm  = {{16{ir[15]}}, ir[15:0]};
  assign simm4 = {simm[29:0], 2'b00};
  assign jtgt  = {pc[31:28], ir[25:0], 2'b00};

  always_comb begin
    ir_we = 1'b0; pc_we = 1'b0; ab_we = 1'b0; res_we = 1'b0; dr_we = 1'b0;
    rf_we = 1'b0; mem_we = 1'b0; iord = 1'b0; asel = 1'b0; wb_dr = 1'b0;
    dst_rd = 1'b0; bsel = B_REG; alu_op = ALU_ADD; pc_src = PC_ALU;
    state_nx = S_IF;
    case (state)
      S_IF: begin
        ir_we = 1'b1;
        pc_we = 1'b1;
        bsel = B_FOUR;
        state_nx = S_ID;
      end
      S_ID: begin
        ab_we = 1'b1;
        res_we = 1'b1;
        bsel = B_IMM4;
        case (opc)
          OP_J: begin
            pc_we = 1'b1;
            pc_src = PC_JMP;
          end
          OP_LW, OP_SW, OP_R, OP_BEQ: state_nx = S_EX;
          default: state_nx = S_IF;
        endcase
      end
      S_EX: begin
        asel = 1'b1;
        case (opc)
          OP_R: begin
            bsel = B_REG;
            alu_op = (funct == FN_AND) ? ALU_AND : ALU_ADD;
            res_we = 1'b1;
            state_nx = S_WB;
          end
          OP_LW, OP_SW: begin
            bsel = B_IMM;
            res_we = 1'b1;
            state_nx = S_MEM;
          end
          OP_BEQ: begin
            bsel = B_REG;
            alu_op = ALU_SUB;
            pc_we = alu_zero;
            pc_src = PC_RES;
          end
          default: state_nx = S_IF;
        endcase
      end
      S_MEM: begin
        iord = 1'b1;
        if (opc == OP_SW) begin
          mem_we = 1'b1;
        end else begin
          dr_we = 1'b1;
          state_nx = S_WB;
        end
      end
      S_WB: begin
        rf_we = 1'b1;
        wb_dr = (opc == OP_LW);
        dst_rd = (opc == OP_R);
      end
      default: state_nx = S_IF;
    endcase
  end

  assign alu_a = asel ? a_q : pc;

  always_comb begin
    case (bsel)
      B_REG:   alu_b = b_q;
      B_FOUR:  alu_b = 32'd4;
      B_IMM:   alu_b = simm;
      default: alu_b = simm4;
    endcase
  end

  always_comb begin
    case (alu_op)
      ALU_AND: alu_y = alu_a & alu_b;
      ALU_SUB: alu_y = alu_a - alu_b;
      default: alu_y = alu_a + alu_b;
    endcase
  end

  assign alu_zero = (alu_y == 32'd0);

  always_comb begin
    case (pc_src)
      PC_RES:  pc_nx = res;
      PC_JMP:  pc_nx = jtgt;
      default: pc_nx = alu_y;
    endcase
  end

  assign wr_addr   = dst_rd ? rd : rt;
  assign wr_data   = wb_dr ? dr : res;
  assign mem_addr  = iord ? res : pc;
  assign mem_wdata = b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IF;
      pc    <= 32'd0;
      ir    <= 32'd0;
      dr    <= 32'd0;
      a_q   <= 32'd0;
      b_q   <= 32'd0;
      res   <= 32'd0;
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else begin
      state <= state_nx;
      if (pc_we)  pc  <= pc_nx;
      if (ir_we)  ir  <= mem_rdata;
      if (dr_we)  dr  <= mem_rdata;
      if (res_we) res <= alu_y;
      if (ab_we) begin
        a_q <= rf[rs];
        b_q <= rf[rt];
      end
      if (rf_we && wr_addr != 5'd0) rf[wr_addr] <= wr_data;
    end
  end
endmodule

module mc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  state,
  input logic [31:0] pc,
  input logic [31:0] ir,
  input logic [31:0] mem_addr,
  input logic        mem_we,
  input logic [31:0] rf0
);
  localparam logic [2:0] C_IF = 3'd0, C_ID = 3'd1, C_EX = 3'd2;
  logic [5:0] op;
  assign op = ir[31:26];

  p_first_fetch_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == 32'd0 && !mem_we));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state == C_IF) |=> (pc == $past(pc) + 32'd4));

  p_ir_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state != C_IF) |=> $stable(ir));

  p_store_ends_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (state == C_IF && !mem_we));

  p_beq_ends_r6: assert property (@(posedge clk) disable iff (rst)
    (state == C_EX && op == 6'h04) |=> (state == C_IF));

  p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
    (state == C_ID && op == 6'h02) |=> (pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00}));

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    rf0 == 32'd0);
endmodule

bind mc_core mc_core_chk u_chk (
  .clk(clk), .rst(rst), .state(state), .pc(pc), .ir(ir),
  .mem_addr(mem_addr), .mem_we(mem_we), .rf0(rf[0])
);

// File: tb/test_mc_core.sv
`timescale 1ns/1ps
module test_mc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;
  logic [31:0] mem [256];
  int checks = 0;
  int fails = 0;
  int we_cnt = 0;
  int cyc;

  localparam logic [31:0] HALT = 32'h100;
  localparam logic [39:0] EXP [8] = '{
    {8'd104, 32'h0000_0000},
    {8'd105, 32'h0000_0055},
    {8'd106, 32'h0000_0066},
    {8'd107, 32'h0000_0013},
    {8'd108, 32'h0000_0004},
    {8'd109, 32'h0000_0003},
    {8'd110, 32'h0000_0007},
    {8'd97,  32'h0000_000C}
  };
  string exp_tag [8] = '{"R8", "R6", "R6", "R9", "R5", "R5", "R3", "R4"};

  mc_core i_mc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  always @(posedge clk) if (!rst && mem_we) we_cnt++;

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] base, logic [4:0] reg_t, logic [15:0] imm);
    return {op, base, reg_t, imm};
  endfunction
  function automatic logic [31:0] enc_r(logic [4:0] s1, logic [4:0] s2, logic [4:0] dst, logic [5:0] fn);
    return {6'h00, s1, s2, dst, 5'h00, fn};
  endfunction
  function automatic logic [31:0] enc_j(logic [31:0] tgt);
    return {6'h02, tgt[27:2]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic run_to_halt();
    while (mem_addr !== HALT && cyc < 2000) step();
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[0]  = enc_i(6'h23, 5'd0, 5'd1, 16'h0180);
    mem[1]  = enc_i(6'h23, 5'd0, 5'd2, 16'h0184);
    mem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'h20);
    mem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h24);
    mem[4]  = enc_i(6'h23, 5'd0, 5'd5, 16'h0188);
    mem[5]  = enc_r(5'd3, 5'd5, 5'd6, 6'h20);
    mem[6]  = enc_r(5'd1, 5'd2, 5'd0, 6'h20);
    mem[7]  = enc_i(6'h2B, 5'd0, 5'd0, 16'h01A0);
    mem[8]  = enc_i(6'h04, 5'd1, 5'd2, 16'h0005);
    mem[9]  = enc_i(6'h04, 5'd3, 5'd3, 16'h0002);
    mem[10] = enc_i(6'h2B, 5'd0, 5'd1, 16'h01A4);
    mem[11] = enc_i(6'h2B, 5'd0, 5'd1, 16'h01A8);
    mem[12] = enc_i(6'h23, 5'd0, 5'd7, 16'h018C);
    mem[13] = enc_i(6'h2B, 5'd7, 5'd3, 16'hFFFC);
    mem[14] = enc_i(6'h2B, 5'd0, 5'd4, 16'h01B0);
    mem[15] = enc_i(6'h2B, 5'd0, 5'd6, 16'h01B4);
    mem[16] = enc_i(6'h2B, 5'd0, 5'd1, 16'h01B8);
    mem[17] = enc_j(HALT);
    mem[64] = enc_j(HALT);
    mem[96]  = 32'h0000_0007;
    mem[97]  = 32'h0000_000C;
    mem[98]  = 32'hFFFF_FFF0;
    mem[99]  = 32'h0000_01B0;
    mem[104] = 32'hDEAD_BEEF;
    mem[105] = 32'h0000_0055;
    mem[106] = 32'h0000_0066;

    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 addr in reset", mem_addr, 32'h0);
    check("R1 we in reset", {31'b0, mem_we}, 32'h0);
    rst = 1'b0;
    cyc = 0;
    check("R1 first fetch addr", mem_addr, 32'h0);
    repeat (3) step();
    check("R3 load address in fourth cycle", mem_addr, 32'h180);
    run_to_halt();
    check("R2 cycles to halt fetch", cyc, 64);
    check("R7 jump reaches halt", mem_addr, HALT);
    check("R4 store strobe count", we_cnt, 5);

    for (int k = 0; k < 8; k++)
      check(exp_tag[k], mem[EXP[k][39:32]], EXP[k][31:0]);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 addr in mid-run reset", mem_addr, 32'h0);
    check("R1 we in mid-run reset", {31'b0, mem_we}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    we_cnt = 0;
    cyc = 0;
    check("R1 refetch from zero", mem_addr, 32'h0);
    run_to_halt();
    check("R2 second run cycles", cyc, 64);
    check("R4 second run store count", we_cnt, 5);
    check("R5 second run sum", mem[107], 32'h13);
    check("R8 second run zero store", mem[104], 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule